// File: doc/BRIEF.md
# Supply Level Set-and-Verify Controller

This block moves a supply performance level to a requested value and then proves that the change happened. A requester presents a 3-bit logical level together with a settle time in clock cycles and pulses a start strobe. The controller maps the logical level onto the register encoding and writes a control word into a level register. The control word holds an enable flag and the encoded level in a shifted field. The controller then waits out the settle time and reads the applied level back from a separate field of the same register.

If the readback equals the encoded request, the operation completes cleanly. If it does not, the completion pulse carries an I/O error flag, and the value actually read is reported beside it. The level register is modelled inside the block. Its applied field follows an enabled write after a fixed, parameterised latency. A settle time shorter than that latency therefore shows up as a verification failure whenever the level really changes.

Top module: `vlevel_setchk`

## Requirements
- R1: After reset, busy, done and error are low, and the level register word reads 0.
- R2: The logical level maps to a register code: levels 0, 1 and 2 keep their value, levels 3 to 6 all become 3, and level 7 stays 7.
- R3: An accepted request writes a control word with bit 7 set as the enable flag, bit 6 clear, and the encoded level in bits 5:3.
- R4: The settle count S is taken from settle_i in the cycle start is accepted. Done is high after the (S+3)-th rising edge, counting the accepting edge as edge 0. Busy is high from the cycle after acceptance until the done cycle.
- R5: The applied level is read from bits 2:0 of the level register and shown on rb_level_o with done. When it equals the encoded request, error stays low.
- R6: When the readback differs from the encoded request, error is high together with done.
- R7: The register model copies bits 5:3 of an enabled write into bits 2:0 exactly APPLY_LAT edges after the write edge, which is edge 1 of the operation. With the default APPLY_LAT of 4, the readback shows the new level if S+1 >= APPLY_LAT and the previous level otherwise.
- R8: A start that arrives while busy is ignored. The target level and the completion time of the running operation are unchanged, and no extra done follows.
- R9: Done is a single-cycle pulse. Error and the reported readback are meaningful only in the done cycle, and error is never high outside it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request strobe, accepted only while idle |
| level_i | input | 3 | Requested logical level |
| settle_i | input | CNT_W | Settle time in clock cycles |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Readback mismatch, valid with done |
| rb_level_o | output | 3 | Level read back from the register, valid with done |
| lvl_reg_o | output | 8 | Current content of the modelled level register |

## Verification
Every result is tied to the accepting edge. The register write lands on edge 1, busy is high from then on, and done, error and readback appear together after edge S+3. The bench counts edges from acceptance and samples on falling edges, so the completion edge must match S+3 exactly, and the next falling edge must show done low again. The expected readback follows from the apply latency: the new code once S+1 reaches APPLY_LAT, the previous code otherwise. Each operation starts from a deliberately different level, and the bench idles long enough between operations for any pending apply to land, so the prior code is always known.

// File: rtl/vlevel_pkg.sv
package vlevel_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_WRITE = 2'd1,
      ST_WAIT  = 2'd2,
      ST_CHECK = 2'd3
   } vl_state_e;

   // Logical level to register code: mid range collapses onto one code.
   function automatic logic [2:0] vl_encode(input logic [2:0] lvl);
      logic [2:0] code;
      if (lvl >= 3'd3 && lvl <= 3'd6) code = 3'd3;
      else                            code = lvl;
      return code;
   endfunction

endpackage

// File: rtl/vlevel_regmodel.sv
module vlevel_regmodel #(
   parameter int REG_W     = 8,
   parameter int LVL_W     = 3,
   parameter int APPLY_LAT = 4,
   parameter int FLAG_BIT  = 7,
   parameter int FIELD_LSB = 3,
   parameter int RB_LSB    = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en_i,
   input  logic [REG_W-1:0] wr_word_i,
   output logic [REG_W-1:0] word_o
);
   localparam int LAT_W = (APPLY_LAT < 1) ? 1 : $clog2(APPLY_LAT + 1);
   localparam logic [REG_W-1:0] RB_MASK = REG_W'(((1 << LVL_W) - 1) << RB_LSB);

   logic [REG_W-1:0] word_q;
   logic             apply_req;

   assign apply_req = wr_en_i && wr_word_i[FLAG_BIT];
   assign word_o    = word_q;

   if (APPLY_LAT < 0) begin : g_bad_lat
      $error("vlevel_regmodel: APPLY_LAT must not be negative");
   end

   if (APPLY_LAT == 0) begin : g_lat_zero
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            word_q <= '0;
         end else if (wr_en_i) begin
            word_q <= (wr_word_i & ~RB_MASK) | (word_q & RB_MASK);
            if (apply_req)
               word_q[RB_LSB +: LVL_W] <= wr_word_i[FIELD_LSB +: LVL_W];
         end
      end
   end else begin : g_lat_delay
      logic [LAT_W-1:0] pend_q;
      logic [LVL_W-1:0] pend_lvl_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            word_q     <= '0;
            pend_q     <= '0;
            pend_lvl_q <= '0;
         end else begin
            if (pend_q == LAT_W'(1))
               word_q[RB_LSB +: LVL_W] <= pend_lvl_q;
            if (pend_q != '0)
               pend_q <= pend_q - 1'b1;
            if (wr_en_i) begin
               word_q[REG_W-1:RB_LSB+LVL_W] <= wr_word_i[REG_W-1:RB_LSB+LVL_W];
               if (apply_req) begin
                  pend_q     <= LAT_W'(APPLY_LAT);
                  pend_lvl_q <= wr_word_i[FIELD_LSB +: LVL_W];
               end
            end
         end
      end

      // R7: the applied field moves only when a pending apply expires
      a_r7_apply_timed: assert property (@(posedge clk) disable iff (!rst_n)
         (word_q[RB_LSB +: LVL_W] != $past(word_q[RB_LSB +: LVL_W]))
            |-> ($past(pend_q) == LAT_W'(1)));
   end

   // R3: an enabled write leaves the flag set in the register
   a_r3_flag_lands: assert property (@(posedge clk) disable iff (!rst_n)
      apply_req |=> word_q[FLAG_BIT]);

endmodule

// File: rtl/vlevel_seq.sv
module vlevel_seq
   import vlevel_pkg::*;
#(
   parameter int CNT_W     = 16,
   parameter int LVL_W     = 3,
   parameter int REG_W     = 8,
   parameter int FLAG_BIT  = 7,
   parameter int FIELD_LSB = 3,
   parameter int RB_LSB    = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [LVL_W-1:0] level_i,
   input  logic [CNT_W-1:0] settle_i,
   input  logic [REG_W-1:0] rd_word_i,
   output logic             wr_en_o,
   output logic [REG_W-1:0] wr_word_o,
   output logic             busy_o,
   output logic             done_o,
   output logic             err_o,
   output logic [LVL_W-1:0] rb_o
);
   vl_state_e        st_q;
   logic [LVL_W-1:0] enc_q;
   logic [CNT_W-1:0] cnt_q;
   logic             done_q;
   logic             err_q;
   logic [LVL_W-1:0] rb_q;
   logic [LVL_W-1:0] rb_now;

   assign rb_now = rd_word_i[RB_LSB +: LVL_W];

   always_comb begin
      wr_word_o                           = '0;
      wr_word_o[FLAG_BIT]                 = 1'b1;
      wr_word_o[FIELD_LSB +: LVL_W]       = enc_q;
      wr_en_o                             = (st_q == ST_WRITE);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         enc_q  <= '0;
         cnt_q  <= '0;
         done_q <= 1'b0;
         err_q  <= 1'b0;
         rb_q   <= '0;
      end else begin
         done_q <= 1'b0;
         err_q  <= 1'b0;
         case (st_q)
            ST_IDLE: begin
               if (start_i) begin
                  enc_q <= vl_encode(level_i);
                  cnt_q <= settle_i;
                  st_q  <= ST_WRITE;
               end
            end
            ST_WRITE: st_q <= ST_WAIT;
            ST_WAIT: begin
               if (cnt_q == '0) st_q  <= ST_CHECK;
               else             cnt_q <= cnt_q - 1'b1;
            end
            ST_CHECK: begin
               done_q <= 1'b1;
               err_q  <= (rb_now != enc_q);
               rb_q   <= rb_now;
               st_q   <= ST_IDLE;
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign busy_o = (st_q != ST_IDLE);
   assign done_o = done_q;
   assign err_o  = err_q;
   assign rb_o   = rb_q;

   // R9: completion is a single-cycle pulse
   a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> !done_q);
   // R9: error never appears without done
   a_r9_err_with_done: assert property (@(posedge clk) disable iff (!rst_n)
      err_q |-> done_q);
   // R8: a start while busy leaves the target untouched
   a_r8_hold_target: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && start_i) |=> $stable(enc_q));
   // R4: busy holds until the operation completes
   a_r4_busy_till_done: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |=> (busy_o || done_q));

endmodule

// File: rtl/vlevel_setchk.sv
module vlevel_setchk #(
   parameter int CNT_W     = 16,
   parameter int APPLY_LAT = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [2:0]       level_i,
   input  logic [CNT_W-1:0] settle_i,
   output logic             busy_o,
   output logic             done_o,
   output logic             err_o,
   output logic [2:0]       rb_level_o,
   output logic [7:0]       lvl_reg_o
);
   localparam int LVL_W     = 3;
   localparam int REG_W     = 8;
   localparam int FLAG_BIT  = 7;
   localparam int FIELD_LSB = 3;
   localparam int RB_LSB    = 0;

   if (CNT_W < 1) begin : g_bad_cnt
      $error("vlevel_setchk: CNT_W must be at least 1");
   end
   if (FIELD_LSB + LVL_W > FLAG_BIT || RB_LSB + LVL_W > FIELD_LSB) begin : g_bad_map
      $error("vlevel_setchk: register fields overlap");
   end

   logic             wr_en;
   logic [REG_W-1:0] wr_word;
   logic [REG_W-1:0] reg_word;

   vlevel_seq #(
      .CNT_W(CNT_W), .LVL_W(LVL_W), .REG_W(REG_W),
      .FLAG_BIT(FLAG_BIT), .FIELD_LSB(FIELD_LSB), .RB_LSB(RB_LSB)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .level_i(level_i),
      .settle_i(settle_i), .rd_word_i(reg_word), .wr_en_o(wr_en),
      .wr_word_o(wr_word), .busy_o(busy_o), .done_o(done_o),
      .err_o(err_o), .rb_o(rb_level_o)
   );

   vlevel_regmodel #(
      .REG_W(REG_W), .LVL_W(LVL_W), .APPLY_LAT(APPLY_LAT),
      .FLAG_BIT(FLAG_BIT), .FIELD_LSB(FIELD_LSB), .RB_LSB(RB_LSB)
   ) u_reg (
      .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en),
      .wr_word_i(wr_word), .word_o(reg_word)
   );

   assign lvl_reg_o = reg_word;

   // R5: a clean completion reports the code that was written
   a_r5_clean_match: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !err_o) |-> (rb_level_o == reg_word[FIELD_LSB +: LVL_W]));
   // R6: an error completion reports a differing code
   a_r6_err_differs: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && err_o) |-> (rb_level_o != reg_word[FIELD_LSB +: LVL_W]));

endmodule

// File: tb/tb_vlevel_setchk.sv
module tb_vlevel_setchk;
   localparam int CNT_W = 16;
   localparam int LAT   = 4;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             start_i = 1'b0;
   logic [2:0]       level_i = '0;
   logic [CNT_W-1:0] settle_i = '0;
   logic             busy_o, done_o, err_o;
   logic [2:0]       rb_level_o;
   logic [7:0]       lvl_reg_o;

   int n_run  = 0;
   int n_fail = 0;
   logic [2:0] prev_code = 3'd0;

   vlevel_setchk #(.CNT_W(CNT_W), .APPLY_LAT(LAT)) dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .level_i(level_i),
      .settle_i(settle_i), .busy_o(busy_o), .done_o(done_o), .err_o(err_o),
      .rb_level_o(rb_level_o), .lvl_reg_o(lvl_reg_o)
   );

   always #5 clk = ~clk;

   function automatic logic [2:0] exp_code(input logic [2:0] l);
      if (l >= 3 && l <= 6) return 3'd3;
      return l;
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic run_op(input logic [2:0] lvl, input int s, input bit poke);
      int  edges;
      bit  busy_ok;
      logic [2:0] want_rb;
      @(negedge clk);
      start_i  = 1'b1;
      level_i  = lvl;
      settle_i = CNT_W'(s);
      @(posedge clk);
      @(negedge clk);
      start_i = 1'b0;
      edges   = 0;
      busy_ok = 1'b1;
      while (!done_o && edges < s + 20) begin
         if (!busy_o) busy_ok = 1'b0;
         if (poke && edges == 1) begin
            start_i = 1'b1;
            level_i = ~lvl;
         end else begin
            start_i = 1'b0;
         end
         @(posedge clk);
         edges++;
         @(negedge clk);
      end
      start_i = 1'b0;
      // R4: completion edge and busy window
      check(edges == s + 3, "R4 done edge", edges, s + 3);
      check(busy_ok, "R4 busy window", busy_ok, 1);
      // R3 / R2: control word fields
      check(lvl_reg_o[7] == 1'b1 && lvl_reg_o[6] == 1'b0, "R3 flag bits",
            lvl_reg_o[7:6], 2);
      check(lvl_reg_o[5:3] == exp_code(lvl), "R2 encoded field",
            lvl_reg_o[5:3], exp_code(lvl));
      // R7 / R5 / R6: readback outcome
      want_rb = (s + 1 >= LAT) ? exp_code(lvl) : prev_code;
      check(rb_level_o == want_rb, "R7 readback", rb_level_o, want_rb);
      if (want_rb == exp_code(lvl))
         check(err_o == 1'b0, "R5 clean completion", err_o, 0);
      else
         check(err_o == 1'b1, "R6 mismatch error", err_o, 1);
      @(negedge clk);
      check(done_o == 1'b0 && err_o == 1'b0, "R9 single pulse", done_o, 0);
      // let any pending apply land, watching for a stray done (R8)
      edges = 0;
      repeat (LAT + 4) begin
         @(negedge clk);
         if (done_o) edges++;
      end
      if (poke) check(edges == 0, "R8 no extra done", edges, 0);
      check(lvl_reg_o[2:0] == exp_code(lvl), "R7 applied later",
            lvl_reg_o[2:0], exp_code(lvl));
      prev_code = exp_code(lvl);
   endtask

   initial begin
      #100000;
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      int settles[6] = '{0, 1, 2, 3, 5, 10};
      repeat (3) @(negedge clk);
      // R1: reset state
      check(!busy_o && !done_o && !err_o, "R1 reset outputs",
            {busy_o, done_o, err_o}, 0);
      check(lvl_reg_o == 8'd0, "R1 reset register", lvl_reg_o, 0);
      rst_n = 1'b1;
      @(negedge clk);
      for (int t = 0; t < 8; t++) begin
         for (int k = 0; k < 6; k++) begin
            run_op((t == 7) ? 3'd0 : 3'd7, 10, 1'b0);
            run_op(3'(t), settles[k], 1'b0);
         end
      end
      // R8: start pulses while busy are ignored
      run_op(3'd1, 6, 1'b1);
      run_op(3'd6, 0, 1'b1);
      run_op(3'd2, 2, 1'b1);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule